// File: doc/BRIEF.md
# Sized and Unaligned Load/Store Unit

This unit carries out the memory instructions of a 32-bit RISC core, one at a time. For each accepted request it forms the effective address from a base register and a sign-extended 16-bit offset. It then checks alignment and issues the read and write requests to a word-wide memory port. For loads it formats the returned word into a register result. That result leaves on a writeback port one slot later than the access, as a delayed load would.

The unit handles signed and unsigned bytes and halfwords, and full words. It also handles two partial-word merge loads and two partial-word merge stores that cover words which straddle an alignment boundary. A merge load combines the selected memory bytes with the destination register's previous contents. A merge store reads the aligned word, splices in the register bytes chosen by the low address bits, and writes the whole word back. A misaligned halfword or word access raises an address-error code and touches nothing. While the cache-isolate status bit is set, every request is dropped without any side effect.

Top module: `lsu_core`

## Requirements
- R1: The effective address is `req_base + sign_extend(req_imm)`. Every bus read or write presents that address with bits 1:0 cleared, and an address error reports the unmodified effective address.
- R2: A halfword access (codes 2, 3, 9) at an odd address, or a full-word access (codes 4, 10) at an address whose bits 1:0 are not zero, pulses `exc_valid` and makes no bus access and no writeback. The code on `exc_code` is 0x04 for a load and 0x05 for a store. Merge operations and byte operations never raise it.
- R3: A request accepted while `cache_iso` is 1 causes no bus read, no bus write, no writeback and no exception.
- R4: Operation codes 0 and 1 load the addressed byte, sign- and zero-extended respectively. Codes 2 and 3 do the same for the addressed halfword. Code 4 loads the whole word. The byte at address offset k occupies bits 8k+7:8k of the memory word.
- R5: Code 5 (merge-left load) with offset k puts memory bytes 0..k into register bytes 3-k..3 and keeps the lower register bytes from `req_old`. Code 6 (merge-right load) with offset k puts memory bytes k..3 into register bytes 0..3-k and keeps the upper register bytes from `req_old`.
- R6: Code 11 (merge-left store) and code 12 (merge-right store) read the aligned word and then write it back with all four byte enables set. The left form with offset k replaces memory bytes 0..k with register bytes 3-k..3. The right form with offset k replaces memory bytes k..3 with register bytes 0..3-k. So the right form at offset 3 keeps memory bits 23:0 and places register bits 7:0 in bits 31:24.
- R7: Code 8 (byte store) writes register bits 7:0 to lane k with only enable bit k set. Code 9 (halfword store) writes register bits 15:0 to lanes k and k+1. Code 10 (word store) writes the whole register with all four enables set.
- R8: A load whose destination index is 0 produces no writeback pulse, and no writeback ever names register 0.
- R9: An address error and a plain store appear in the cycle after the request is accepted. A load writeback and a merge-store write appear in the cycle after the third clock edge counted from acceptance. `busy` is high while a read is outstanding, and requests made while busy are ignored.
- R10: After reset, every output is low.
- R11: Operation codes 7, 13, 14 and 15 are ignored: no bus access, no writeback, no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 4 | Operation code; bit 3 set means store |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed address offset |
| req_wdata | input | 32 | Store source register value |
| req_old | input | 32 | Previous destination register value |
| req_rd | input | 5 | Destination register index |
| cache_iso | input | 1 | Cache-isolate status; suppresses the request |
| busy | output | 1 | An accepted access is still in progress |
| bus_rd | output | 1 | Read request, one cycle |
| bus_wr | output | 1 | Write request, one cycle |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_be | output | 4 | Byte-lane write enables |
| bus_wdata | output | 32 | Write data, lane-placed |
| bus_rdata | input | 32 | Read data, valid the cycle after the edge that samples `bus_rd` |
| wb_valid | output | 1 | Writeback pulse |
| wb_rd | output | 5 | Writeback register index |
| wb_data | output | 32 | Writeback value |
| exc_valid | output | 1 | Address-error pulse |
| exc_code | output | 5 | Exception cause code |
| exc_addr | output | 32 | Faulting effective address |

## Verification
An address error or a plain store shows at the outputs one edge after acceptance. A load writeback or a merge-store write shows three edges after acceptance, because the read request, the memory's registered data and the result register each take one edge. The bench samples on falling edges and records the index of the falling edge at which each pulse appears. It checks that index as well as the value, so a result that is right but arrives one cycle early or late is still reported. Store effects are judged on the bench memory word after the access window, against a word predicted from the prior contents.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam logic [3:0] OP_LD_BS    = 4'd0;
  localparam logic [3:0] OP_LD_BU    = 4'd1;
  localparam logic [3:0] OP_LD_HS    = 4'd2;
  localparam logic [3:0] OP_LD_HU    = 4'd3;
  localparam logic [3:0] OP_LD_W     = 4'd4;
  localparam logic [3:0] OP_LD_LEFT  = 4'd5;
  localparam logic [3:0] OP_LD_RIGHT = 4'd6;
  localparam logic [3:0] OP_ST_B     = 4'd8;
  localparam logic [3:0] OP_ST_H     = 4'd9;
  localparam logic [3:0] OP_ST_W     = 4'd10;
  localparam logic [3:0] OP_ST_LEFT  = 4'd11;
  localparam logic [3:0] OP_ST_RIGHT = 4'd12;

  localparam int EXC_W = 5;
  localparam logic [EXC_W-1:0] EXC_LOAD_ADDR  = 5'h04;
  localparam logic [EXC_W-1:0] EXC_STORE_ADDR = 5'h05;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } lsu_state_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] base,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0] ea,
  output logic            known,
  output logic            is_store,
  output logic            is_merge,
  output logic            misaligned
);
  localparam int NLANE = XLEN / 8;
  localparam int OFF_W = $clog2(NLANE);

  logic half_sz;
  logic word_sz;

  assign ea = base + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    known    = 1'b1;
    half_sz  = 1'b0;
    word_sz  = 1'b0;
    is_merge = 1'b0;
    case (op)
      OP_LD_BS, OP_LD_BU, OP_ST_B: ;
      OP_LD_HS, OP_LD_HU, OP_ST_H: half_sz = 1'b1;
      OP_LD_W, OP_ST_W:            word_sz = 1'b1;
      OP_LD_LEFT, OP_LD_RIGHT:     ;
      OP_ST_LEFT, OP_ST_RIGHT:     is_merge = 1'b1;
      default:                     known = 1'b0;
    endcase
    is_store   = op[3];
    misaligned = (half_sz && ea[0]) || (word_sz && (|ea[OFF_W-1:0]));
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]                    op,
  input  logic [$clog2(XLEN/8)-1:0]     off,
  input  logic [XLEN-1:0]               mem,
  input  logic [XLEN-1:0]               old,
  output logic [XLEN-1:0]               res
);
  localparam int NLANE = XLEN / 8;

  logic [XLEN-1:0] shifted;
  int              k;

  always_comb begin
    shifted = mem >> (8 * off);
    k       = int'(off);
    res     = mem;
    case (op)
      OP_LD_BS: res = {{(XLEN-8){shifted[7]}}, shifted[7:0]};
      OP_LD_BU: res = {{(XLEN-8){1'b0}}, shifted[7:0]};
      OP_LD_HS: res = {{(XLEN-16){shifted[15]}}, shifted[15:0]};
      OP_LD_HU: res = {{(XLEN-16){1'b0}}, shifted[15:0]};
      OP_LD_LEFT: begin
        for (int i = 0; i < NLANE; i++) begin
          if (i >= NLANE - 1 - k) res[8*i +: 8] = mem[8*(i-(NLANE-1-k)) +: 8];
          else                    res[8*i +: 8] = old[8*i +: 8];
        end
      end
      OP_LD_RIGHT: begin
        for (int i = 0; i < NLANE; i++) begin
          if (i <= NLANE - 1 - k) res[8*i +: 8] = mem[8*(i+k) +: 8];
          else                    res[8*i +: 8] = old[8*i +: 8];
        end
      end
      default: res = mem;
    endcase
  end
endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt
  import lsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]                    op,
  input  logic [$clog2(XLEN/8)-1:0]     off,
  input  logic [XLEN-1:0]               mem,
  input  logic [XLEN-1:0]               regv,
  output logic [XLEN-1:0]               wdata,
  output logic [XLEN/8-1:0]             be
);
  localparam int NLANE = XLEN / 8;

  int k;

  always_comb begin
    k     = int'(off);
    wdata = regv;
    be    = '1;
    case (op)
      OP_ST_B: begin
        wdata = regv << (8 * off);
        be    = {{(NLANE-1){1'b0}}, 1'b1} << off;
      end
      OP_ST_H: begin
        wdata = regv << (8 * off);
        be    = {{(NLANE-2){1'b0}}, 2'b11} << off;
      end
      OP_ST_LEFT: begin
        for (int i = 0; i < NLANE; i++) begin
          if (i <= k) wdata[8*i +: 8] = regv[8*(i+NLANE-1-k) +: 8];
          else        wdata[8*i +: 8] = mem[8*i +: 8];
        end
      end
      OP_ST_RIGHT: begin
        for (int i = 0; i < NLANE; i++) begin
          if (i >= k) wdata[8*i +: 8] = regv[8*(i-k) +: 8];
          else        wdata[8*i +: 8] = mem[8*i +: 8];
        end
      end
      default: begin
        wdata = regv;
        be    = '1;
      end
    endcase
  end
endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [XLEN-1:0]   req_base,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic [XLEN-1:0]   req_old,
  input  logic [RIDX_W-1:0] req_rd,
  input  logic              cache_iso,
  output logic              busy,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [XLEN-1:0]   bus_addr,
  output logic [XLEN/8-1:0] bus_be,
  output logic [XLEN-1:0]   bus_wdata,
  input  logic [XLEN-1:0]   bus_rdata,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_rd,
  output logic [XLEN-1:0]   wb_data,
  output logic              exc_valid,
  output logic [EXC_W-1:0]  exc_code,
  output logic [XLEN-1:0]   exc_addr
);
  localparam int NLANE = XLEN / 8;
  localparam int OFF_W = $clog2(NLANE);

  lsu_state_e        state_q;
  logic [3:0]        op_q;
  logic [OFF_W-1:0]  off_q;
  logic [XLEN-1:0]   wdata_q;
  logic [XLEN-1:0]   old_q;
  logic [RIDX_W-1:0] rd_q;

  logic [XLEN-1:0]   ea;
  logic              known, is_store, is_merge, misaligned;
  logic [XLEN-1:0]   ea_word;
  logic              accept;
  logic [XLEN-1:0]   d_wdata, m_wdata, ld_res;
  logic [NLANE-1:0]  d_be, m_be;

  lsu_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) agen_i (
    .op(req_op), .base(req_base), .imm(req_imm), .ea(ea),
    .known(known), .is_store(is_store), .is_merge(is_merge),
    .misaligned(misaligned)
  );

  // direct store lane placement from the live request
  lsu_store_fmt #(.XLEN(XLEN)) dstore_i (
    .op(req_op), .off(ea[OFF_W-1:0]), .mem('0), .regv(req_wdata),
    .wdata(d_wdata), .be(d_be)
  );

  // merge store from the captured request and the returned word
  lsu_store_fmt #(.XLEN(XLEN)) mstore_i (
    .op(op_q), .off(off_q), .mem(bus_rdata), .regv(wdata_q),
    .wdata(m_wdata), .be(m_be)
  );

  lsu_load_fmt #(.XLEN(XLEN)) load_i (
    .op(op_q), .off(off_q), .mem(bus_rdata), .old(old_q), .res(ld_res)
  );

  assign ea_word = {ea[XLEN-1:OFF_W], {OFF_W{1'b0}}};
  assign accept  = req_valid && (state_q == ST_IDLE) && known && !cache_iso;
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      off_q     <= '0;
      wdata_q   <= '0;
      old_q     <= '0;
      rd_q      <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_wdata <= '0;
      wb_valid  <= 1'b0;
      wb_rd     <= '0;
      wb_data   <= '0;
      exc_valid <= 1'b0;
      exc_code  <= '0;
      exc_addr  <= '0;
    end else begin
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      wb_valid  <= 1'b0;
      exc_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= req_op;
            off_q   <= ea[OFF_W-1:0];
            wdata_q <= req_wdata;
            old_q   <= req_old;
            rd_q    <= req_rd;
            if (misaligned) begin
              exc_valid <= 1'b1;
              exc_code  <= is_store ? EXC_STORE_ADDR : EXC_LOAD_ADDR;
              exc_addr  <= ea;
            end else if (is_store && !is_merge) begin
              bus_wr    <= 1'b1;
              bus_addr  <= ea_word;
              bus_be    <= d_be;
              bus_wdata <= d_wdata;
            end else begin
              bus_rd   <= 1'b1;
              bus_addr <= ea_word;
              state_q  <= ST_WAIT;
            end
          end
        end
        ST_WAIT: state_q <= ST_DATA;
        ST_DATA: begin
          state_q <= ST_IDLE;
          if (op_q[3]) begin
            bus_wr    <= 1'b1;
            bus_be    <= m_be;
            bus_wdata <= m_wdata;
          end else if (rd_q != '0) begin
            wb_valid <= 1'b1;
            wb_rd    <= rd_q;
            wb_data  <= ld_res;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_core_chk.sv
module lsu_core_chk #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              cache_iso,
  input logic              busy,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [XLEN-1:0]   bus_addr,
  input logic [XLEN/8-1:0] bus_be,
  input logic              wb_valid,
  input logic [RIDX_W-1:0] wb_rd,
  input logic              exc_valid,
  input logic [4:0]        exc_code
);
  // R1
  bus_addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> (bus_addr[1:0] == 2'b00));

  // R2
  exc_code_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> ((exc_code == 5'h04 || exc_code == 5'h05) && !bus_rd && !bus_wr && !wb_valid));

  // R3
  iso_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cache_iso && !busy) |=> (!bus_rd && !bus_wr && !exc_valid && !busy));

  // R7
  be_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 || $countones(bus_be) == 4));

  // R8
  wb_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_rd != '0));

  // R9
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (!bus_rd && busy));

  // R9
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_rd, bus_wr, wb_valid, exc_valid}));
endmodule

bind lsu_core lsu_core_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .cache_iso(cache_iso),
  .busy(busy), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_be(bus_be), .wb_valid(wb_valid), .wb_rd(wb_rd),
  .exc_valid(exc_valid), .exc_code(exc_code)
);

// File: tb/lsu_core_tb.sv
module lsu_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_imm = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_old = '0;
  logic [4:0]  req_rd = '0;
  logic        cache_iso = 1'b0;
  logic        busy, bus_rd, bus_wr;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;
  logic        wb_valid, exc_valid;
  logic [4:0]  wb_rd, exc_code;
  logic [31:0] wb_data, exc_addr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_core dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
    .req_old(req_old), .req_rd(req_rd), .cache_iso(cache_iso),
    .busy(busy), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_addr(exc_addr)
  );

  // bench memory: 256 words, registered read, byte-enabled write
  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= (i * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
      bus_rdata <= '0;
    end else begin
      if (bus_rd) bus_rdata <= mem[bus_addr[9:2]];
      if (bus_wr) begin
        for (int b = 0; b < 4; b++)
          if (bus_be[b]) mem[bus_addr[9:2]][8*b +: 8] <= bus_wdata[8*b +: 8];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit ref_known(input logic [3:0] op);
    return !(op == 4'd7 || op >= 4'd13);
  endfunction

  function automatic bit ref_mis(input logic [3:0] op, input logic [31:0] ea);
    if (op == 4'd2 || op == 4'd3 || op == 4'd9) return ea[0];
    if (op == 4'd4 || op == 4'd10) return ea[1:0] != 2'b00;
    return 1'b0;
  endfunction

  function automatic logic [31:0] ref_load(input logic [3:0] op, input logic [1:0] off,
                                           input logic [31:0] m, input logic [31:0] old);
    logic [7:0]  b;
    logic [15:0] h;
    b = 8'(m >> (8 * off));
    h = 16'(m >> (8 * off));
    case (op)
      4'd0: return {{24{b[7]}}, b};
      4'd1: return {24'h0, b};
      4'd2: return {{16{h[15]}}, h};
      4'd3: return {16'h0, h};
      4'd5: case (off)
              2'd0: return {m[7:0], old[23:0]};
              2'd1: return {m[15:0], old[15:0]};
              2'd2: return {m[23:0], old[7:0]};
              default: return m;
            endcase
      4'd6: case (off)
              2'd0: return m;
              2'd1: return {old[31:24], m[31:8]};
              2'd2: return {old[31:16], m[31:16]};
              default: return {old[31:8], m[31:24]};
            endcase
      default: return m;
    endcase
  endfunction

  function automatic logic [31:0] ref_store(input logic [3:0] op, input logic [1:0] off,
                                            input logic [31:0] m, input logic [31:0] r);
    logic [31:0] mask;
    case (op)
      4'd8: begin
        mask = 32'hFF << (8 * off);
        return (m & ~mask) | ((r & 32'hFF) << (8 * off));
      end
      4'd9: return off[1] ? {r[15:0], m[15:0]} : {m[31:16], r[15:0]};
      4'd11: case (off)
               2'd0: return {m[31:8], r[31:24]};
               2'd1: return {m[31:16], r[31:16]};
               2'd2: return {m[31:24], r[31:8]};
               default: return r;
             endcase
      4'd12: case (off)
               2'd0: return r;
               2'd1: return {r[23:0], m[7:0]};
               2'd2: return {r[15:0], m[15:0]};
               default: return {r[7:0], m[23:0]};
             endcase
      default: return r;
    endcase
  endfunction

  task automatic do_op(input logic [3:0] op, input logic [31:0] base, input logic [15:0] imm,
                       input logic [31:0] wd, input logic [31:0] old, input logic [4:0] rd,
                       input bit iso);
    logic [31:0] ea, pre, exp_mem, exp_wb, last_addr;
    logic [7:0]  idx;
    bit mis, known, is_st, merge_st;
    int rd_cnt, wr_cnt, wb_cnt, exc_cnt, wb_at, wr_at, exc_at;
    logic [31:0] wb_val, exc_a;
    logic [4:0]  wb_r, exc_c;
    ea = base + {{16{imm[15]}}, imm};
    idx = ea[9:2];
    known = ref_known(op);
    mis = ref_mis(op, ea);
    is_st = op[3];
    merge_st = (op == 4'd11 || op == 4'd12);
    rd_cnt = 0; wr_cnt = 0; wb_cnt = 0; exc_cnt = 0;
    wb_at = -1; wr_at = -1; exc_at = -1;
    wb_val = '0; exc_a = '0; wb_r = '0; exc_c = '0; last_addr = '0;
    @(negedge clk);
    pre = mem[idx];
    req_op = op; req_base = base; req_imm = imm; req_wdata = wd;
    req_old = old; req_rd = rd; cache_iso = iso; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; cache_iso = 1'b0;
    for (int s = 0; s < 6; s++) begin
      if (s > 0) @(negedge clk);
      if (bus_rd) begin rd_cnt++; last_addr = bus_addr; end
      if (bus_wr) begin wr_cnt++; wr_at = s; last_addr = bus_addr; end
      if (wb_valid) begin wb_cnt++; wb_at = s; wb_val = wb_data; wb_r = wb_rd; end
      if (exc_valid) begin exc_cnt++; exc_at = s; exc_a = exc_addr; exc_c = exc_code; end
    end
    if (iso || !known) begin
      chk(rd_cnt + wr_cnt + wb_cnt + exc_cnt == 0, iso ? "R3 isolate quiet" : "R11 undefined quiet",
          32'(rd_cnt + wr_cnt + wb_cnt + exc_cnt), 0);
      chk(mem[idx] == pre, iso ? "R3 memory kept" : "R11 memory kept", mem[idx], pre);
    end else if (mis) begin
      chk(exc_cnt == 1 && exc_at == 0, "R2/R9 error pulse timing", 32'(exc_at), 0);
      chk(exc_c == (is_st ? 5'h05 : 5'h04), "R2 error code", 32'(exc_c), is_st ? 5 : 4);
      chk(exc_a == ea, "R1 error address", exc_a, ea);
      chk(rd_cnt + wr_cnt + wb_cnt == 0, "R2 no access", 32'(rd_cnt + wr_cnt + wb_cnt), 0);
    end else if (!is_st) begin
      exp_wb = ref_load(op, ea[1:0], pre, old);
      chk(last_addr == {ea[31:2], 2'b00}, "R1 read address", last_addr, {ea[31:2], 2'b00});
      if (rd == 5'd0) begin
        chk(wb_cnt == 0, "R8 no writeback to r0", 32'(wb_cnt), 0);
      end else begin
        chk(wb_cnt == 1 && wb_at == 2, "R9 load writeback timing", 32'(wb_at), 2);
        chk(wb_r == rd, "R8 writeback index", 32'(wb_r), 32'(rd));
        chk(wb_val == exp_wb, (op == 4'd5 || op == 4'd6) ? "R5 merge load data" : "R4 load data",
            wb_val, exp_wb);
      end
    end else begin
      exp_mem = ref_store(op, ea[1:0], pre, wd);
      chk(last_addr == {ea[31:2], 2'b00}, "R1 write address", last_addr, {ea[31:2], 2'b00});
      if (merge_st) begin
        chk(rd_cnt == 1 && wr_cnt == 1 && wr_at == 2, "R9 merge store timing", 32'(wr_at), 2);
        chk(mem[idx] == exp_mem, "R6 merge store data", mem[idx], exp_mem);
      end else begin
        chk(rd_cnt == 0 && wr_cnt == 1 && wr_at == 0, "R9 plain store timing", 32'(wr_at), 0);
        chk(mem[idx] == exp_mem, "R7 plain store data", mem[idx], exp_mem);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [3:0] ops [12];
    logic [7:0] rb;
    int wr_seen;
    ops = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10, 4'd11, 4'd12};
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk({busy, bus_rd, bus_wr, wb_valid, exc_valid} == 5'b0, "R10 reset outputs",
        32'({busy, bus_rd, bus_wr, wb_valid, exc_valid}), 0);
    chk(bus_addr == 0 && bus_be == 0 && wb_data == 0 && exc_code == 0, "R10 reset data",
        bus_addr | 32'(bus_be) | wb_data | 32'(exc_code), 0);

    // directed corner cases
    do_op(4'd0, 32'h100, 16'h0003, 0, 32'hDEAD_BEEF, 5'd3, 0);   // R4 signed byte
    do_op(4'd1, 32'h100, 16'h0003, 0, 32'hDEAD_BEEF, 5'd4, 0);   // R4 unsigned byte
    do_op(4'd2, 32'h104, 16'h0002, 0, 0, 5'd5, 0);               // R4 signed half
    do_op(4'd3, 32'h104, 16'h0001, 0, 0, 5'd5, 0);               // R2 odd half
    do_op(4'd10, 32'h108, 16'h0002, 32'h1, 0, 5'd1, 0);          // R2 store word misaligned
    do_op(4'd12, 32'h110, 16'h0003, 32'hAABB_CCDD, 0, 5'd1, 0);  // R6 right store off 3
    do_op(4'd11, 32'h114, 16'h0000, 32'h1122_3344, 0, 5'd1, 0);  // R6 left store off 0
    do_op(4'd5, 32'h118, 16'h0001, 0, 32'hCAFE_F00D, 5'd7, 0);   // R5 merge-left load
    do_op(4'd6, 32'h118, 16'h0002, 0, 32'hCAFE_F00D, 5'd7, 0);   // R5 merge-right load
    do_op(4'd4, 32'h120, 16'h0000, 0, 0, 5'd0, 0);               // R8 r0 destination
    do_op(4'd10, 32'h124, 16'h0000, 32'h7777_7777, 0, 5'd0, 1);  // R3 isolated store
    do_op(4'd3, 32'h125, 16'h0000, 0, 0, 5'd2, 1);               // R3 isolated misaligned
    do_op(4'd7, 32'h128, 16'h0000, 0, 0, 5'd2, 0);               // R11 undefined
    do_op(4'd14, 32'h128, 16'h0000, 0, 0, 5'd2, 0);              // R11 undefined
    do_op(4'd9, 32'h0001_0130, 16'hFF02, 32'h0000_BEEF, 0, 0, 0); // R1 negative offset
    do_op(4'd8, 32'h140, 16'h0002, 32'h0000_00A5, 0, 0, 0);      // R7 byte lane 2

    // R9 requests while busy are ignored
    @(negedge clk);
    req_op = 4'd4; req_base = 32'h150; req_imm = 16'h0; req_rd = 5'd9; req_valid = 1'b1;
    @(negedge clk);
    req_op = 4'd10; req_wdata = 32'h0BAD_0BAD; req_base = 32'h154;
    wr_seen = 0;
    for (int s = 0; s < 6; s++) begin
      if (s == 2) req_valid = 1'b0;
      if (bus_wr) wr_seen++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(wr_seen == 0, "R9 busy request ignored", 32'(wr_seen), 0);
    chk(mem[8'h55] != 32'h0BAD_0BAD, "R9 busy memory kept", mem[8'h55], 32'h0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      rb = 8'($urandom);
      do_op(ops[$urandom % 12], 32'h100 + ($urandom % 512), {{8{rb[7]}}, rb},
            $urandom, $urandom, 5'($urandom), ($urandom % 16) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule